// File: doc/BRIEF.md
# Instruction Decode and Execute Unit

This block is the purely combinational heart of a simple single-issue integer pipeline. It takes a 32-bit instruction word together with the values already read for its two source registers. In the same cycle it returns the arithmetic or logic result, the index of the register that should receive that result, a write strobe for that register, and a memory address built from the base register and the signed 16-bit offset field.

The supported subset is as follows:
- register-to-register add, subtract, OR, XOR and NOR;
- shifts of the second source by the constant in the shift-amount field;
- immediate add with sign extension;
- immediate AND and OR with zero extension;
- load of an immediate into the upper half of the word.

Every other encoding raises the illegal flag. While that flag is high, the result is zero and no register write happens. The address output is produced for every word, so the surrounding load/store logic can use it whatever the opcode.

Top module: `instrDecodeAlu`

## Requirements
- R1: For opcode 0 (bits 31:26) the destination index is bits 15:11. For the legal immediate opcodes it is bits 20:16.
- R2: Opcode 0 with function (bits 5:0) 0x21 returns rs+rt and 0x23 returns rs−rt, both modulo 2^32.
- R3: Opcode 0 with function 0x25, 0x26 or 0x27 returns rs OR rt, rs XOR rt, or NOT(rs OR rt) respectively.
- R4: Opcode 0 with function 0x00, 0x02 or 0x03 shifts rt by bits 10:6. These are a left shift, a logical right shift and an arithmetic right shift respectively, and the arithmetic shift fills with rt bit 31.
- R5: Opcode 0x09 returns rs plus bits 15:0 sign-extended to 32 bits.
- R6: Opcodes 0x0C and 0x0D return rs AND or rs OR bits 15:0 zero-extended to 32 bits.
- R7: Opcode 0x0F returns bits 15:0 in result bits 31:16, with result bits 15:0 zero.
- R8: The address output always equals rs plus bits 15:0 sign-extended, for any instruction word.
- R9: The register write strobe is low whenever the destination index is 0. For a legal instruction with a nonzero destination it is high.
- R10: Any other opcode, or any other function value under opcode 0, sets the illegal flag, drives the result to 0 and holds the write strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rsVal | input | 32 | Value of the register named by bits 25:21 |
| rtVal | input | 32 | Value of the register named by bits 20:16 |
| aluResult | output | 32 | Computed result (0 when illegal) |
| destIdx | output | 5 | Destination register index |
| regWrEn | output | 1 | Register write strobe |
| memAddr | output | 32 | Base plus signed offset |
| illegal | output | 1 | Unsupported encoding |

## Verification
Random legal words are drawn for every supported opcode and function, with random operands. This separates each operation from its neighbours and catches a swapped destination field. Directed words pin the corners:
- negative immediates, which tell sign extension from zero extension;
- shifts of a negative value by 0 and by 31, which tell arithmetic fill from logical fill;
- a subtraction that wraps;
- a destination of register 0.

Fully random words then exercise the illegal path and the address adder on encodings outside the subset.

// File: rtl/decPkg.sv
package decPkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned IDX_W  = 5;
  parameter int unsigned OP_W   = 6;
  localparam int unsigned IMM_W = WORD_W / 2;
  localparam int unsigned SH_W  = $clog2(WORD_W);

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } aluOp_e;

  typedef struct packed {
    aluOp_e aluOp;
    logic   useImm;
    logic   signExt;
    logic   destIsRd;
    logic   illegal;
  } ctrl_t;
endpackage

// File: rtl/decCtrl.sv
module decCtrl
  import decPkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output ctrl_t             ctrl,
  output logic [IDX_W-1:0]  destIdx,
  output logic              regWrEn
);
  logic [OP_W-1:0] opField;
  logic [OP_W-1:0] funcField;

  assign opField   = instr[WORD_W-1 -: OP_W];
  assign funcField = instr[OP_W-1:0];

  always_comb begin
    ctrl = '{aluOp: ALU_ADD, useImm: 1'b0, signExt: 1'b0, destIsRd: 1'b0, illegal: 1'b1};
    case (opField)
      6'h00: begin
        ctrl.destIsRd = 1'b1;
        ctrl.illegal  = 1'b0;
        case (funcField)
          6'h21: ctrl.aluOp = ALU_ADD;
          6'h23: ctrl.aluOp = ALU_SUB;
          6'h25: ctrl.aluOp = ALU_OR;
          6'h26: ctrl.aluOp = ALU_XOR;
          6'h27: ctrl.aluOp = ALU_NOR;
          6'h00: ctrl.aluOp = ALU_SLL;
          6'h02: ctrl.aluOp = ALU_SRL;
          6'h03: ctrl.aluOp = ALU_SRA;
          default: ctrl.illegal = 1'b1;
        endcase
      end
      6'h09: begin ctrl.aluOp = ALU_ADD; ctrl.useImm = 1'b1; ctrl.signExt = 1'b1; ctrl.illegal = 1'b0; end
      6'h0C: begin ctrl.aluOp = ALU_AND; ctrl.useImm = 1'b1; ctrl.illegal = 1'b0; end
      6'h0D: begin ctrl.aluOp = ALU_OR;  ctrl.useImm = 1'b1; ctrl.illegal = 1'b0; end
      6'h0F: begin ctrl.aluOp = ALU_LUI; ctrl.useImm = 1'b1; ctrl.illegal = 1'b0; end
      default: ;
    endcase
  end

  assign destIdx = ctrl.destIsRd ? instr[IMM_W-1 -: IDX_W] : instr[IMM_W+IDX_W-1 -: IDX_W];
  assign regWrEn = !ctrl.illegal && (destIdx != '0);

  always_comb begin
    a_r9_no_zero_write: assert (!(regWrEn && destIdx == '0))
      else $error("R9: write strobe raised for register 0");
    a_r10_illegal_no_write: assert (!(ctrl.illegal && regWrEn))
      else $error("R10: write strobe raised for illegal word");
    a_r1_imm_dest: assert (ctrl.illegal || opField == '0 || destIdx == instr[20:16])
      else $error("R1: immediate form wrote wrong field");
  end
endmodule

// File: rtl/decDatapath.sv
module decDatapath
  import decPkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] rsVal,
  input  logic [WORD_W-1:0] rtVal,
  input  ctrl_t             ctrl,
  output logic [WORD_W-1:0] aluResult,
  output logic [WORD_W-1:0] memAddr
);
  logic [IMM_W-1:0]  immField;
  logic [SH_W-1:0]   shamt;
  logic [WORD_W-1:0] immSigned;
  logic [WORD_W-1:0] immExt;
  logic [WORD_W-1:0] opB;

  assign immField  = instr[IMM_W-1:0];
  assign shamt     = instr[OP_W+SH_W-1 -: SH_W];
  assign immSigned = {{(WORD_W-IMM_W){immField[IMM_W-1]}}, immField};
  assign immExt    = ctrl.signExt ? immSigned : {{(WORD_W-IMM_W){1'b0}}, immField};
  assign opB       = ctrl.useImm ? immExt : rtVal;
  assign memAddr   = rsVal + immSigned;

  always_comb begin
    if (ctrl.illegal) begin
      aluResult = '0;
    end else begin
      case (ctrl.aluOp)
        ALU_ADD: aluResult = rsVal + opB;
        ALU_SUB: aluResult = rsVal - opB;
        ALU_AND: aluResult = rsVal & opB;
        ALU_OR:  aluResult = rsVal | opB;
        ALU_XOR: aluResult = rsVal ^ opB;
        ALU_NOR: aluResult = ~(rsVal | opB);
        ALU_SLL: aluResult = rtVal << shamt;
        ALU_SRL: aluResult = rtVal >> shamt;
        ALU_SRA: aluResult = $unsigned($signed(rtVal) >>> shamt);
        ALU_LUI: aluResult = {immField, {(WORD_W-IMM_W){1'b0}}};
        default: aluResult = '0;
      endcase
    end
  end

  always_comb begin
    a_r4_sra_fill: assert (ctrl.illegal || ctrl.aluOp != ALU_SRA || aluResult[WORD_W-1] == rtVal[WORD_W-1])
      else $error("R4: arithmetic shift lost sign");
    a_r7_lui_low: assert (ctrl.illegal || ctrl.aluOp != ALU_LUI || aluResult[IMM_W-1:0] == '0)
      else $error("R7: low half not zero");
    a_r6_and_upper: assert (ctrl.illegal || ctrl.aluOp != ALU_AND || aluResult[WORD_W-1:IMM_W] == '0)
      else $error("R6: zero-extended AND has upper bits");
    a_r10_illegal_zero: assert (!ctrl.illegal || aluResult == '0)
      else $error("R10: illegal word produced a result");
  end
endmodule

// File: rtl/instrDecodeAlu.sv
module instrDecodeAlu
  import decPkg::*;
(
  input  logic [31:0] instr,
  input  logic [31:0] rsVal,
  input  logic [31:0] rtVal,
  output logic [31:0] aluResult,
  output logic [4:0]  destIdx,
  output logic        regWrEn,
  output logic [31:0] memAddr,
  output logic        illegal
);
  ctrl_t ctrl;

  decCtrl uCtrl (
    .instr   (instr),
    .ctrl    (ctrl),
    .destIdx (destIdx),
    .regWrEn (regWrEn)
  );

  decDatapath uPath (
    .instr     (instr),
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .ctrl      (ctrl),
    .aluResult (aluResult),
    .memAddr   (memAddr)
  );

  assign illegal = ctrl.illegal;
endmodule

// File: tb/tb_instrDecodeAlu.sv
module tb_instrDecodeAlu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr, rsVal, rtVal, aluResult, memAddr;
  logic [4:0]  destIdx;
  logic        regWrEn, illegal;
  int checks = 0, fails = 0;
  bit done = 0;

  instrDecodeAlu dut (.*);

  function automatic void model(input logic [31:0] w, a, b,
      output logic [31:0] res, output logic [4:0] d, output logic ill, output string tag);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    logic [4:0] sh = w[10:6];
    logic [31:0] se = {{16{w[15]}}, w[15:0]};
    logic [31:0] ze = {16'h0, w[15:0]};
    ill = 0; res = 0; d = w[20:16]; tag = "R10";
    if (op == 0) begin
      d = w[15:11];
      case (fn)
        6'h21: begin res = a + b; tag = "R2"; end
        6'h23: begin res = a - b; tag = "R2"; end
        6'h25: begin res = a | b; tag = "R3"; end
        6'h26: begin res = a ^ b; tag = "R3"; end
        6'h27: begin res = ~(a | b); tag = "R3"; end
        6'h00: begin res = b << sh; tag = "R4"; end
        6'h02: begin res = b >> sh; tag = "R4"; end
        6'h03: begin
          res = b >> sh;
          for (int i = 0; i < 32; i++) if (i >= 32 - sh) res[i] = b[31];
          tag = "R4";
        end
        default: ill = 1;
      endcase
    end else if (op == 6'h09) begin res = a + se; tag = "R5"; end
    else if (op == 6'h0C) begin res = a & ze; tag = "R6"; end
    else if (op == 6'h0D) begin res = a | ze; tag = "R6"; end
    else if (op == 6'h0F) begin res = {w[15:0], 16'h0}; tag = "R7"; end
    else ill = 1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (instr %h)", tag, what, act, exp, instr);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    logic [31:0] res; logic [4:0] d; logic ill; string tag;
    @(negedge clk);
    instr = w; rsVal = a; rtVal = b;
    #1;
    model(w, a, b, res, d, ill, tag);
    chk("R10", "illegal", {31'h0, illegal}, {31'h0, ill});
    chk(ill ? "R10" : tag, "result", aluResult, res);
    chk("R8", "address", memAddr, a + {{16{w[15]}}, w[15:0]});
    if (!ill) chk("R1", "dest", {27'h0, destIdx}, {27'h0, d});
    chk(ill ? "R10" : "R9", "write", {31'h0, regWrEn}, {31'h0, !ill && d != 0});
  endtask

  function automatic logic [31:0] rword(logic [5:0] op, logic [5:0] fn);
    logic [31:0] w = $urandom;
    w[31:26] = op;
    if (op == 0) w[5:0] = fn;
    return w;
  endfunction

  initial begin
    logic [5:0] ops[4] = '{6'h09, 6'h0C, 6'h0D, 6'h0F};
    logic [5:0] fns[8] = '{6'h21, 6'h23, 6'h25, 6'h26, 6'h27, 6'h00, 6'h02, 6'h03};
    void'($urandom(32'd1234));
    instr = 0; rsVal = 0; rtVal = 0;
    #1;
    chk("R9", "initial write", {31'h0, regWrEn}, 32'h0);
    chk("R10", "initial illegal", {31'h0, illegal}, 32'h0);
    // directed corners
    apply(32'h0022_1823, 32'h0000_0001, 32'h0000_0002);  // R2 wrapping subtract
    apply(32'h2422_FFFF, 32'h0000_0010, 32'h0);          // R5 negative immediate
    apply(32'h3022_FFFF, 32'hFFFF_FFFF, 32'h0);          // R6 zero extension
    apply(32'h3422_8000, 32'h0000_0001, 32'h0);          // R6 ori upper clean
    apply(32'h3C05_DEAD, 32'h1234_5678, 32'h0);          // R7
    apply(32'h0000_2FC3, 32'h0, 32'h8000_0000);          // R4 sra by 31
    apply(32'h0000_2FC2, 32'h0, 32'h8000_0000);          // R4 srl by 31
    apply(32'h0000_2803, 32'h0, 32'h8000_0001);          // R4 sra by 0
    apply(32'h0022_0021, 32'h5, 32'h6);                  // R9 dest zero
    apply(32'h2420_0005, 32'h5, 32'h6);                  // R9 imm dest zero
    apply(32'h0022_1820, 32'h5, 32'h6);                  // R10 bad func
    apply(32'h8C22_FFFC, 32'h0000_1000, 32'h0);          // R8, R10 load word
    for (int i = 0; i < 400; i++) apply(rword(fns[$urandom_range(7)], 0) & 32'h03FF_FFFF | 32'h0, $urandom, $urandom);
    for (int i = 0; i < 400; i++) begin
      logic [5:0] o = ops[$urandom_range(3)];
      apply(rword(o, 0), $urandom, $urandom);
    end
    for (int i = 0; i < 400; i++) begin
      logic [5:0] f = fns[$urandom_range(7)];
      apply(rword(6'h00, f), $urandom, $urandom);
    end
    for (int i = 0; i < 400; i++) apply($urandom, $urandom, $urandom);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule